// File: doc/BRIEF.md
# DTMF Transceiver Host Port

This block is the host-side register port of a DTMF transceiver. A 4-bit microprocessor bus reaches it through an active-low chip select, one register-select line, a read/not-write line and an access strobe. The strobe need not run continuously. The port turns each strobed access into one of four operations:
- load the code of the tone pair to send,
- return the code of the last tone pair received,
- write a control register,
- read a status word.

Tone synthesis and tone detection stay outside this block. They talk to it through simple level and pulse signals.

Two control registers sit behind one address. A one-shot pointer, armed by a bit in the first register, sends exactly one later control write to the second register. The status word holds sticky flags, and a completed status read clears them. The block also drives an open-drain interrupt request, modelled as an active-low drive enable. That pin is shared by mode: it can carry the interrupt flag, the call-progress square wave, or the inverted delayed-steering level in test mode.

The receive register is loaded only by a capture pulse from the steering logic. Each transmit register write also gives the generator a one-cycle load pulse.

Top module: `dtmf_host_port`

## Requirements
- R1: An access happens only when the strobe rises while the chip select is low. The operation is chosen as follows:
  - select=0 with write loads the transmit code, and `tx_load` pulses for exactly one cycle.
  - select=0 with read returns the receive code.
  - select=1 with write goes to a control register.
  - select=1 with read returns the status word.
- R2: After reset the following hold:
  - Tone output is off.
  - DTMF mode is selected, and interrupts are disabled.
  - Burst mode is on.
  - Dual tone and row are selected, and test mode is off.
  - The status flags are zero, and the interrupt pin is released (`irq_out_n`=1).
- R3: The first control register holds tone enable in bit 0, call-progress mode in bit 1 (1 = call progress), interrupt enable in bit 2 and the pointer in bit 3. Writing it with bit 3 = 1 sends only the next control write to the second register. Later control writes return to the first register, and a write to one register leaves the other unchanged.
- R4: The second control register holds burst disable in bit 0 (0 = burst on), test mode in bit 1, single tone in bit 2 (1 = single) and column select in bit 3 (1 = column).
- R5: The status word holds the interrupt flag in bit 0, transmit-empty in bit 1 and receive-full in bit 2. Bit 3 shows the live delayed-steering level.
- R6: Status bits 0 to 2 clear when the strobe falls at the end of a status read. A set event in the clearing cycle takes priority over the clear.
- R7: A transmitter-ready pulse sets transmit-empty only while burst mode is on. Transmit-empty is held clear while burst mode is off.
- R8: A capture pulse loads the receive code and sets receive-full. The receive register changes on no other event.
- R9: The interrupt flag is set whenever transmit-empty or receive-full is set. Only a status read clears it.
- R10: With interrupts enabled in DTMF mode and test mode off, the pin is driven low while the interrupt flag is set. With interrupts disabled and test mode not in effect, the pin is released.
- R11: With call-progress mode and interrupts both enabled, the pin follows the call-progress square wave (high = released).
- R12: Test mode in DTMF mode makes the pin the inverse of delayed steering, and this overrides the interrupt source. Test mode has no effect in call-progress mode.
- R13: A strobe taken with the chip select high changes nothing. That covers the registers, the load pulse and the status flags, and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_rs | input | 1 | Register select |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_stb | input | 1 | Access strobe, active high |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, 0 when not reading |
| rx_capture | input | 1 | One-cycle pulse: received code valid |
| rx_code | input | 4 | Decoded received tone code |
| dly_steer | input | 1 | Delayed steering level from the receiver |
| tx_ready | input | 1 | One-cycle pulse: burst and pause finished |
| cp_wave | input | 1 | Call-progress square wave |
| tx_code | output | 4 | Code of the tone pair to generate |
| tx_load | output | 1 | One-cycle pulse after a transmit write |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode selected |
| burst_on | output | 1 | Burst mode active |
| test_mode | output | 1 | Test mode bit |
| single_tone | output | 1 | Single-tone generation |
| col_sel | output | 1 | Single tone from the column group |
| irq_out_n | output | 1 | 0 = drive the interrupt pin low, 1 = release |

## Verification
A pointer left armed shows up on the very next control write, because that write lands in the wrong register and a mode output takes the wrong value. A flag that is not cleared after a read shows up in the next status read, and on `irq_out_n` two cycles after the strobe falls. A wrong pin-source priority shows at once on `irq_out_n` when the mode bits, `cp_wave` or `dly_steer` change. The table walks those mode combinations, and directed sequences cover clear-on-read, burst gating and deselected accesses.

// File: rtl/dhp_pkg.sv
package dhp_pkg;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic irq_en;
    logic cp_mode;
    logic tone_en;
  } cra_t;

  typedef struct packed {
    logic col_sel;
    logic single;
    logic test;
    logic burst_dis;
  } crb_t;

  typedef struct packed {
    logic steer;
    logic rx_full;
    logic tx_empty;
    logic irq_flag;
  } stat_t;
endpackage

// File: rtl/dhp_bus_decode.sv
module dhp_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic rs,
  input  logic rnw,
  input  logic stb,
  output logic tx_wr,
  output logic ctrl_wr,
  output logic stat_clr
);
  logic stb_q, acc_stat_q, acc_stat_d;
  logic stb_rise, sel;

  always_comb begin
    sel        = ~sel_n;
    stb_rise   = stb & ~stb_q;
    tx_wr      = stb_rise & sel & ~rnw & ~rs;
    ctrl_wr    = stb_rise & sel & ~rnw & rs;
    stat_clr   = ~stb & stb_q & acc_stat_q;
    acc_stat_d = acc_stat_q;
    if (stb_rise) acc_stat_d = sel & rnw & rs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q      <= 1'b0;
      acc_stat_q <= 1'b0;
    end else begin
      stb_q      <= stb;
      acc_stat_q <= acc_stat_d;
    end
  end

  p_one_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_wr, ctrl_wr, stat_clr}));
  p_wr_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr || ctrl_wr) |=> !(tx_wr || ctrl_wr));
  p_desel_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !(tx_wr || ctrl_wr));
endmodule

// File: rtl/dhp_ctrl_regs.sv
module dhp_ctrl_regs
  import dhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [NIB_W-1:0] wdata,
  output cra_t             cra,
  output crb_t             crb
);
  cra_t cra_q, cra_d;
  crb_t crb_q, crb_d;
  logic ptr_q, ptr_d;

  always_comb begin
    cra_d = cra_q;
    crb_d = crb_q;
    ptr_d = ptr_q;
    if (ctrl_wr) begin
      if (ptr_q) begin
        crb_d = crb_t'(wdata);
        ptr_d = 1'b0;
      end else begin
        cra_d = cra_t'(wdata[NIB_W-2:0]);
        ptr_d = wdata[NIB_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cra_q <= '0;
      crb_q <= '0;
      ptr_q <= 1'b0;
    end else if (ctrl_wr) begin
      cra_q <= cra_d;
      crb_q <= crb_d;
      ptr_q <= ptr_d;
    end
  end

  assign cra = cra_q;
  assign crb = crb_q;

  p_ptr_oneshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ptr_q) |=> (!ptr_q && $stable(cra_q)));
  p_crb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ptr_q) |=> $stable(crb_q));
endmodule

// File: rtl/dhp_status.sv
module dhp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_capture,
  input  logic tx_ready,
  input  logic burst_on,
  input  logic stat_clr,
  output logic irq_flag,
  output logic tx_empty,
  output logic rx_full
);
  logic irq_d, txe_d, rxf_d, tx_set;

  always_comb begin
    tx_set = tx_ready & burst_on;
    rxf_d  = rx_full;
    txe_d  = tx_empty;
    irq_d  = irq_flag;
    if (rx_capture)    rxf_d = 1'b1;
    else if (stat_clr) rxf_d = 1'b0;
    if (!burst_on)     txe_d = 1'b0;
    else if (tx_set)   txe_d = 1'b1;
    else if (stat_clr) txe_d = 1'b0;
    if (rx_capture || tx_set) irq_d = 1'b1;
    else if (stat_clr)        irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      tx_empty <= 1'b0;
      rx_full  <= 1'b0;
    end else begin
      irq_flag <= irq_d;
      tx_empty <= txe_d;
      rx_full  <= rxf_d;
    end
  end

  p_rx_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_capture |=> rx_full);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !rx_capture && !tx_ready) |=> (!rx_full && !tx_empty && !irq_flag));
  p_burst_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_on |=> !tx_empty);
  p_flag_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full || tx_empty) |-> irq_flag);
endmodule

// File: rtl/dhp_irq_mux.sv
module dhp_irq_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic cp_mode,
  input  logic test_mode,
  input  logic irq_flag,
  input  logic cp_wave,
  input  logic dly_steer,
  output logic irq_out_n
);
  logic test_eff;

  always_comb begin
    test_eff = test_mode & ~cp_mode;
    if (test_eff)            irq_out_n = ~dly_steer;
    else if (irq_en && cp_mode) irq_out_n = cp_wave;
    else if (irq_en)         irq_out_n = ~irq_flag;
    else                     irq_out_n = 1'b1;
  end

  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !(test_mode && !cp_mode)) |-> irq_out_n);
  p_flag_pull_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !cp_mode && !test_mode && irq_flag) |-> !irq_out_n);
  p_test_steer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !cp_mode && dly_steer) |-> !irq_out_n);
endmodule

// File: rtl/dtmf_host_port.sv
module dtmf_host_port
  import dhp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel_n,
  input  logic             bus_rs,
  input  logic             bus_rnw,
  input  logic             bus_stb,
  input  logic [NIB_W-1:0] bus_wdata,
  output logic [NIB_W-1:0] bus_rdata,
  input  logic             rx_capture,
  input  logic [NIB_W-1:0] rx_code,
  input  logic             dly_steer,
  input  logic             tx_ready,
  input  logic             cp_wave,
  output logic [NIB_W-1:0] tx_code,
  output logic             tx_load,
  output logic             tone_en,
  output logic             cp_mode,
  output logic             burst_on,
  output logic             test_mode,
  output logic             single_tone,
  output logic             col_sel,
  output logic             irq_out_n
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_sync_q[SYNC_STAGES-1];

  logic tx_wr, ctrl_wr, stat_clr;
  cra_t cra;
  crb_t crb;
  stat_t stat;
  logic irq_flag, tx_empty, rx_full;
  logic [NIB_W-1:0] rx_q, tx_q;
  logic tx_load_q;

  dhp_bus_decode u_dec (
    .clk(clk), .rst_n(rst_i), .sel_n(bus_sel_n), .rs(bus_rs), .rnw(bus_rnw),
    .stb(bus_stb), .tx_wr(tx_wr), .ctrl_wr(ctrl_wr), .stat_clr(stat_clr)
  );

  dhp_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_i), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .cra(cra), .crb(crb)
  );

  dhp_status u_stat (
    .clk(clk), .rst_n(rst_i), .rx_capture(rx_capture), .tx_ready(tx_ready),
    .burst_on(burst_on), .stat_clr(stat_clr), .irq_flag(irq_flag),
    .tx_empty(tx_empty), .rx_full(rx_full)
  );

  dhp_irq_mux u_irq (
    .clk(clk), .rst_n(rst_i), .irq_en(cra.irq_en), .cp_mode(cra.cp_mode),
    .test_mode(crb.test), .irq_flag(irq_flag), .cp_wave(cp_wave),
    .dly_steer(dly_steer), .irq_out_n(irq_out_n)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rx_q <= '0;
    else if (rx_capture) rx_q <= rx_code;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tx_q      <= '0;
      tx_load_q <= 1'b0;
    end else begin
      tx_load_q <= tx_wr;
      if (tx_wr) tx_q <= bus_wdata;
    end
  end

  always_comb begin
    stat = '{steer: dly_steer, rx_full: rx_full, tx_empty: tx_empty, irq_flag: irq_flag};
    bus_rdata = '0;
    if (!bus_sel_n && bus_rnw) bus_rdata = bus_rs ? stat : rx_q;
  end

  assign tx_code     = tx_q;
  assign tx_load     = tx_load_q;
  assign tone_en     = cra.tone_en;
  assign cp_mode     = cra.cp_mode;
  assign burst_on    = ~crb.burst_dis;
  assign test_mode   = crb.test;
  assign single_tone = crb.single;
  assign col_sel     = crb.col_sel;

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_i)
    !rx_capture |=> $stable(rx_q));
  p_load_pulse_r1: assert property (@(posedge clk) disable iff (!rst_i)
    tx_load |=> !tx_load);
endmodule

// File: tb/sim_dtmf_host_port.sv
module sim_dtmf_host_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel_n = 1'b1, bus_rs = 1'b0, bus_rnw = 1'b0, bus_stb = 1'b0;
  logic [3:0] bus_wdata = '0, bus_rdata, rx_code = '0, tx_code;
  logic rx_capture = 1'b0, dly_steer = 1'b0, tx_ready = 1'b0, cp_wave = 1'b0;
  logic tx_load, tone_en, cp_mode, burst_on, test_mode, single_tone, col_sel, irq_out_n;
  int checks = 0, errors = 0, loads = 0, cycles = 0;
  logic [3:0] rv;

  always #4 clk = ~clk;

  dtmf_host_port u0 (.*);

  always @(posedge clk) begin
    if (tx_load) loads++;
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic rs, input logic rnw, input logic sel_n,
                        input logic [3:0] wd, output logic [3:0] rd);
    @(negedge clk);
    bus_sel_n = sel_n; bus_rs = rs; bus_rnw = rnw; bus_wdata = wd; bus_stb = 1'b1;
    @(negedge clk); @(negedge clk);
    rd = bus_rdata;
    bus_stb = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_sel_n = 1'b1; bus_rnw = 1'b0;
  endtask

  task automatic pulse_capture(input logic [3:0] code);
    @(negedge clk); rx_code = code; rx_capture = 1'b1;
    @(negedge clk); rx_capture = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ready();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    @(negedge clk);
  endtask

  // {cra[2:0] irq_en,cp,tone ; crb[3:0] col,single,test,burst_dis ; dly ; cp_wave ; expected irq_out_n}
  localparam logic [9:0] VEC [9] = '{
    {3'b000, 4'b0000, 1'b0, 1'b0, 1'b1},
    {3'b100, 4'b0000, 1'b0, 1'b0, 1'b1},
    {3'b110, 4'b0000, 1'b0, 1'b0, 1'b0},
    {3'b110, 4'b0000, 1'b0, 1'b1, 1'b1},
    {3'b000, 4'b0010, 1'b1, 1'b0, 1'b0},
    {3'b000, 4'b0010, 1'b0, 1'b0, 1'b1},
    {3'b010, 4'b0010, 1'b1, 1'b0, 1'b1},
    {3'b111, 4'b1111, 1'b1, 1'b0, 1'b0},
    {3'b101, 4'b0110, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk("R2 controls", {tone_en, cp_mode, burst_on, test_mode, single_tone, col_sel}, 6'b001000);
    chk("R2 irq released", irq_out_n, 1);
    bus_op(1'b1, 1'b1, 1'b0, 4'h0, rv);
    chk("R2 status zero", rv, 0);

    // Table: R3 R4 R11 R12 R10
    for (int i = 0; i < 9; i++) begin
      logic [9:0] v;
      v = VEC[i];
      bus_op(1'b1, 1'b0, 1'b0, {1'b1, v[9:7]}, rv);
      bus_op(1'b1, 1'b0, 1'b0, v[6:3], rv);
      @(negedge clk); dly_steer = v[2]; cp_wave = v[1];
      @(negedge clk);
      chk($sformatf("R3 R4 fields vec %0d", i),
          {tone_en, cp_mode, burst_on, test_mode, single_tone, col_sel},
          {v[7], v[8], ~v[3], v[4], v[5], v[6]});
      chk($sformatf("R11 R12 pin vec %0d", i), irq_out_n, v[0]);
    end
    @(negedge clk); dly_steer = 1'b0; cp_wave = 1'b0;
    bus_op(1'b1, 1'b0, 1'b0, 4'b1000, rv);
    bus_op(1'b1, 1'b0, 1'b0, 4'b0000, rv);

    // R1 transmit write
    bus_op(1'b0, 1'b0, 1'b0, 4'hA, rv);
    chk("R1 tx code", tx_code, 4'hA);
    chk("R1 single load pulse", loads, 1);

    // R3 pointer returns to first register
    bus_op(1'b1, 1'b0, 1'b0, 4'b0001, rv);
    chk("R3 write to first reg", tone_en, 1);
    chk("R3 second reg untouched", burst_on, 1);
    bus_op(1'b1, 1'b0, 1'b0, 4'b0000, rv);

    // R13 deselected accesses
    bus_op(1'b1, 1'b0, 1'b1, 4'b0001, rv);
    chk("R13 ctrl ignored", tone_en, 0);
    bus_op(1'b0, 1'b0, 1'b1, 4'h5, rv);
    chk("R13 tx ignored", {tx_code, 4'(loads)}, {4'hA, 4'd1});

    // R8 R9 R10 R5 R6 receive path
    bus_op(1'b1, 1'b0, 1'b0, 4'b0100, rv);
    chk("R10 released no flag", irq_out_n, 1);
    pulse_capture(4'h6);
    chk("R10 pin low on flag", irq_out_n, 0);
    bus_op(1'b0, 1'b1, 1'b0, 4'h0, rv);
    chk("R1 R8 rx read", rv, 4'h6);
    @(negedge clk); rx_code = 4'h3;
    bus_op(1'b0, 1'b1, 1'b0, 4'h0, rv);
    chk("R8 rx held without capture", rv, 4'h6);
    bus_op(1'b1, 1'b1, 1'b1, 4'h0, rv);
    chk("R13 deselected read data", rv, 0);
    chk("R13 deselected read no clear", irq_out_n, 0);
    bus_op(1'b1, 1'b1, 1'b0, 4'h0, rv);
    chk("R5 R9 status rx full", rv, 4'b0101);
    chk("R6 pin released after read", irq_out_n, 1);
    bus_op(1'b1, 1'b1, 1'b0, 4'h0, rv);
    chk("R6 status cleared", rv, 0);

    // R7 transmit ready in burst mode
    pulse_ready();
    bus_op(1'b1, 1'b1, 1'b0, 4'h0, rv);
    chk("R7 R9 tx empty set", rv, 4'b0011);
    bus_op(1'b1, 1'b0, 1'b0, 4'b1100, rv);
    bus_op(1'b1, 1'b0, 1'b0, 4'b0001, rv);
    pulse_ready();
    bus_op(1'b1, 1'b1, 1'b0, 4'h0, rv);
    chk("R7 no set burst off", rv, 0);
    bus_op(1'b1, 1'b0, 1'b0, 4'b1100, rv);
    bus_op(1'b1, 1'b0, 1'b0, 4'b0000, rv);
    pulse_ready();
    bus_op(1'b1, 1'b0, 1'b0, 4'b1100, rv);
    bus_op(1'b1, 1'b0, 1'b0, 4'b0001, rv);
    bus_op(1'b1, 1'b1, 1'b0, 4'h0, rv);
    chk("R7 burst off clears tx empty", rv, 4'b0001);

    // R5 live steering bit
    @(negedge clk); dly_steer = 1'b1;
    bus_op(1'b1, 1'b1, 1'b0, 4'h0, rv);
    chk("R5 steering bit", rv, 4'b1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule